// File: doc/BRIEF.md
# Accumulator Instruction Cycle Controller

This block is the control and register core of a small one-address machine. It holds a program counter, instruction register, memory address and memory buffer registers, an accumulator and a status word. It steps through separate fetch, indirect, execute and interrupt subcycles. Every word moves between the registers and a single memory port, which has separate read and write strobes.

An instruction word has `AW + 5` bits. The top four bits are the opcode and bit `AW` is the indirect flag. The low `AW` bits are the address field. Memory answers each request with a ready pulse. Data returned on a read is taken in the cycle where ready is high. A write completes in the cycle where ready is high.

An external interrupt request is examined once per instruction, after execute. When it is accepted, the program counter is saved to a fixed save word and control moves to a fixed handler address. A return instruction resumes the interrupted program.

Top module: `acc_cycle_ctrl`

## Requirements
- R1: Fetch reads the word at the program counter and increments the program counter by one. Without a branch, skip or interrupt, successive fetches use consecutive addresses.
- R2: When bit `AW` of the instruction is 1, the word at the address field is read first. Its low `AW` bits then serve as the effective address for the operand access or branch target.
- R3: LOAD (opcode 0) copies the word at the effective address into the accumulator. AND (opcode 4) replaces the accumulator with its bitwise AND with that word. STOR (opcode 1) writes the accumulator to the effective address.
- R4: ADD (opcode 2) and SUB (opcode 3) update the accumulator and all four flags. `status_o` is {ie, v, c, z, n}: n is the result's top bit and z marks a zero result. For ADD, c is the carry out. For SUB, c is the borrow, set when the operand is larger than the accumulator taken as unsigned. v marks two's-complement overflow.
- R5: Every opcode other than ADD and SUB leaves n, z, c and v unchanged.
- R6: BRZ (opcode 5), BRP (opcode 6) and BRN (opcode 7) load the effective address into the program counter when, respectively, z=1, (z=0 and n=0), or n=1. Otherwise execution falls through.
- R7: ISZ (opcode 8) reads the operand, adds one and writes the result back to the same address. When that result is zero, the next instruction is skipped.
- R8: When `irq` is high and ie=1 at the end of an instruction, the controller writes the next program counter value to `SAVE_ADDR`, clears ie, and fetches next from `HANDLER_ADDR`.
- R9: While ie=0, a high `irq` is not taken. It is taken after the first instruction that ends with ie=1.
- R10: RTI (opcode 9) reads `SAVE_ADDR`, loads its low `AW` bits into the program counter and sets ie. Opcodes 10 to 15 do nothing.
- R11: A read or write request stays asserted, with a stable address, until ready. Read and write strobes are never high together.
- R12: After reset no request is active, the accumulator and flags are zero and ie=1. The first fetch is from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request level |
| mem_addr | output | AW | Memory address (memory address register) |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | AW+5 | Write data (memory buffer register) |
| mem_rdata | input | AW+5 | Read data, valid with ready |
| mem_ready | input | 1 | Completes the current request |
| acc_o | output | AW+5 | Accumulator |
| status_o | output | 5 | {ie, v, c, z, n} |

## Verification
The bench builds the block with `AW = 8`, which gives a 13-bit word, `SAVE_ADDR = 240` and `HANDLER_ADDR = 192`. A 13-bit word lets a short program reach signed overflow, carry, borrow and an ISZ wrap to zero, and the whole memory fits in a small bench array. The bench memory varies its wait from zero to two cycles, so request holding is exercised on every subcycle. A second interrupt is raised while the handler runs with ie clear. This shows that the interrupt is held off and then taken right after the return.

// File: rtl/acc_cycle_ctrl.sv
module acc_cycle_ctrl #(
  parameter int AW = 11,
  parameter int unsigned SAVE_ADDR = 2**AW - 1,
  parameter int unsigned HANDLER_ADDR = 2**(AW-1),
  localparam int DW = AW + 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [DW-1:0] acc_o,
  output logic [4:0]    status_o
);
  localparam logic [AW-1:0] SAVE_A = AW'(SAVE_ADDR);
  localparam logic [AW-1:0] HAND_A = AW'(HANDLER_ADDR);
  localparam logic [3:0] OP_LOAD = 4'd0, OP_STOR = 4'd1, OP_ADD = 4'd2, OP_SUB = 4'd3,
                         OP_AND = 4'd4, OP_BRZ = 4'd5, OP_BRP = 4'd6, OP_BRN = 4'd7,
                         OP_ISZ = 4'd8, OP_RTI = 4'd9;

  typedef enum logic [3:0] {
    S_F_ADDR, S_F_RD, S_F_DEC, S_I_RD, S_EXEC, S_X_RD, S_X_OP, S_X_WR, S_CHK, S_INT_WR
  } state_t;

  state_t        state;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, mbr, acc;
  logic          fn, fz, fc, fv, ie;

  logic [3:0]  op;
  logic [DW:0] sum, dif;
  logic        add_v, sub_v;

  assign op    = ir[DW-1:DW-4];
  assign sum   = {1'b0, acc} + {1'b0, mbr};
  assign dif   = {1'b0, acc} - {1'b0, mbr};
  assign add_v = (acc[DW-1] == mbr[DW-1]) && (sum[DW-1] != acc[DW-1]);
  assign sub_v = (acc[DW-1] != mbr[DW-1]) && (dif[DW-1] != acc[DW-1]);

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = (state == S_F_RD) || (state == S_I_RD) || (state == S_X_RD);
  assign mem_wr    = (state == S_X_WR) || (state == S_INT_WR);
  assign acc_o     = acc;
  assign status_o  = {ie, fv, fc, fz, fn};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_F_ADDR;
      pc <= '0; mar <= '0; ir <= '0; mbr <= '0; acc <= '0;
      fn <= 1'b0; fz <= 1'b0; fc <= 1'b0; fv <= 1'b0; ie <= 1'b1;
    end else begin
      case (state)
        S_F_ADDR: begin
          mar   <= pc;
          state <= S_F_RD;
        end
        S_F_RD: if (mem_ready) begin
          mbr   <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_F_DEC;
        end
        S_F_DEC: begin
          ir    <= mbr;
          mar   <= mbr[AW-1:0];
          state <= mbr[AW] ? S_I_RD : S_EXEC;
        end
        S_I_RD: if (mem_ready) begin
          mbr   <= mem_rdata;
          mar   <= mem_rdata[AW-1:0];
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_CHK;
          case (op)
            OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_ISZ: state <= S_X_RD;
            OP_STOR: begin mbr <= acc; state <= S_X_WR; end
            OP_BRZ: if (fz) pc <= mar;
            OP_BRP: if (!fz && !fn) pc <= mar;
            OP_BRN: if (fn) pc <= mar;
            OP_RTI: begin mar <= SAVE_A; state <= S_X_RD; end
            default: ;
          endcase
        end
        S_X_RD: if (mem_ready) begin
          mbr   <= mem_rdata;
          state <= S_X_OP;
        end
        S_X_OP: begin
          state <= S_CHK;
          case (op)
            OP_LOAD: acc <= mbr;
            OP_AND:  acc <= acc & mbr;
            OP_ADD: begin
              acc <= sum[DW-1:0];
              fn <= sum[DW-1]; fz <= (sum[DW-1:0] == '0); fc <= sum[DW]; fv <= add_v;
            end
            OP_SUB: begin
              acc <= dif[DW-1:0];
              fn <= dif[DW-1]; fz <= (dif[DW-1:0] == '0); fc <= dif[DW]; fv <= sub_v;
            end
            OP_ISZ: begin mbr <= mbr + 1'b1; state <= S_X_WR; end
            OP_RTI: begin pc <= mbr[AW-1:0]; ie <= 1'b1; end
            default: ;
          endcase
        end
        S_X_WR: if (mem_ready) begin
          if (op == OP_ISZ && mbr == '0) pc <= pc + 1'b1;
          state <= S_CHK;
        end
        S_CHK: begin
          if (irq && ie) begin
            mbr   <= {{(DW-AW){1'b0}}, pc};
            mar   <= SAVE_A;
            ie    <= 1'b0;
            state <= S_INT_WR;
          end else begin
            state <= S_F_ADDR;
          end
        end
        S_INT_WR: if (mem_ready) begin
          pc    <= HAND_A;
          state <= S_F_ADDR;
        end
        default: state <= S_F_ADDR;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ready |=> (mem_rd || mem_wr) && $stable(mem_addr) && $stable(mem_wr)); // R11
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_F_RD) && mem_ready |=> pc == $past(pc) + 1'b1); // R1
  AST_SAVE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INT_WR) |-> !ie && (mar == SAVE_A)); // R8
  AST_NO_INT_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHK) && !ie |=> state == S_F_ADDR); // R9
  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_X_OP) && (op != OP_ADD) && (op != OP_SUB) |=> $stable({fn, fz, fc, fv})); // R5
endmodule

// File: tb/acc_cycle_ctrl_bench.sv
module acc_cycle_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = AW + 5;
  localparam int SAVE = 240;
  localparam int HND = 192;
  localparam int TRIG1 = 12;
  localparam int TRIG2 = 192;
  localparam int ENDPC = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, mem_ready;
  logic [DW-1:0] mem_wdata, mem_rdata, acc_o;
  logic [4:0] status_o;

  always #5 clk = ~clk;

  acc_cycle_ctrl #(.AW(AW), .SAVE_ADDR(SAVE), .HANDLER_ADDR(HND)) u_acc_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .acc_o(acc_o), .status_o(status_o));

  int nchk = 0, nfail = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(int op, int ind, int a);
    return {op[3:0], ind[0], a[7:0]};
  endfunction

  function automatic logic [DW-1:0] prog(int a);
    case (a)
      0:  return ins(0, 0, 'h80);
      1:  return ins(2, 0, 'h81);
      2:  return ins(1, 0, 'h86);
      3:  return ins(7, 0, 5);
      4:  return ins(1, 0, 'h87);
      5:  return ins(2, 0, 'h82);
      6:  return ins(6, 0, 8);
      7:  return ins(1, 0, 'h87);
      8:  return ins(0, 1, 'h83);
      9:  return ins(3, 0, 'h84);
      10: return ins(5, 0, 12);
      11: return ins(1, 0, 'h87);
      12: return ins(8, 0, 'h85);
      13: return ins(8, 0, 'h85);
      14: return ins(1, 0, 'h87);
      15: return ins(0, 0, 'h8A);
      16: return ins(4, 0, 'h80);
      17: return ins(1, 0, 'h88);
      18: return ins(3, 0, 'h81);
      19: return ins(1, 1, 'h83);
      20: return ins(5, 0, 0);
      21: return ins(7, 0, 0);
      22: return ins(15, 0, 0);
      23: return ins(6, 0, 23);
      'h80: return 13'h0FFF;
      'h81: return 13'h0001;
      'h82: return 13'h1FFF;
      'h83: return 13'h0084;
      'h84: return 13'h0005;
      'h85: return 13'h1FFE;
      'h8A: return 13'h0F0F;
      192: return ins(1, 0, 'h89);
      193: return ins(2, 0, 'h81);
      194: return ins(9, 0, 0);
      default: return '0;
    endcase
  endfunction

  // bench memory with 0..2 cycle waits
  logic [DW-1:0] mem [256];
  int wcnt, wsel;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= prog(i);
      mem_ready <= 1'b0; wcnt <= 0; wsel <= 0; mem_rdata <= '0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0; wcnt <= 0;
      if (mem_wr) mem[mem_addr] <= mem_wdata;
    end else if (mem_rd || mem_wr) begin
      if (wcnt >= wsel % 3) begin
        mem_ready <= 1'b1; mem_rdata <= mem[mem_addr]; wsel <= wsel + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  // behavioural reference model: instruction-level, expands into bus transactions
  logic [DW-1:0] mm [256];
  int m_pc = 0;
  logic [DW-1:0] m_acc = '0;
  bit m_n, m_z, m_c, m_v, m_ie = 1'b1;
  bit m_irq = 1'b0, m_f1 = 1'b0, m_f2 = 1'b0;
  string m_tag = "R12";
  int q_kind[$], q_addr[$], q_data[$], q_acc[$], q_st[$];
  string q_req[$];

  task automatic push(int k, int a, int d, string r);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_req.push_back(r);
    q_acc.push_back(int'(m_acc)); q_st.push_back(int'({m_ie, m_v, m_c, m_z, m_n}));
  endtask

  task automatic model_step();
    logic [DW-1:0] w, r;
    logic [DW:0] s;
    int op, ea, fa;
    string nt;
    fa = m_pc;
    push(0, m_pc, 0, m_tag);
    w = mm[m_pc]; m_pc = (m_pc + 1) % 256;
    if ((fa == TRIG1 && !m_f1) || (fa == TRIG2 && !m_f2)) begin
      m_irq = 1'b1;
      if (fa == TRIG1) m_f1 = 1'b1; else m_f2 = 1'b1;
    end
    op = int'(w[DW-1:DW-4]); ea = int'(w[AW-1:0]);
    nt = "R1";
    if (w[AW]) begin push(1, ea, 0, "R2"); ea = int'(mm[ea][AW-1:0]); end
    case (op)
      0: begin push(1, ea, 0, "R3"); m_acc = mm[ea]; nt = "R5"; end
      1: begin push(2, ea, int'(m_acc), "R3"); mm[ea] = m_acc; nt = "R5"; end
      2, 3: begin
        push(1, ea, 0, "R4");
        if (op == 2) s = {1'b0, m_acc} + {1'b0, mm[ea]};
        else s = {1'b0, m_acc} - {1'b0, mm[ea]};
        r = s[DW-1:0];
        m_v = (op == 2) ? (m_acc[DW-1] == mm[ea][DW-1] && r[DW-1] != m_acc[DW-1])
                        : (m_acc[DW-1] != mm[ea][DW-1] && r[DW-1] != m_acc[DW-1]);
        m_c = s[DW]; m_n = r[DW-1]; m_z = (r == '0); m_acc = r; nt = "R4";
      end
      4: begin push(1, ea, 0, "R3"); m_acc = m_acc & mm[ea]; nt = "R5"; end
      5: begin if (m_z) m_pc = ea; nt = "R6"; end
      6: begin if (!m_z && !m_n) m_pc = ea; nt = "R6"; end
      7: begin if (m_n) m_pc = ea; nt = "R6"; end
      8: begin
        push(1, ea, 0, "R7");
        r = mm[ea] + 1'b1; push(2, ea, int'(r), "R7"); mm[ea] = r;
        if (r == '0) m_pc = (m_pc + 1) % 256;
        nt = "R7";
      end
      9: begin push(1, SAVE, 0, "R10"); m_pc = int'(mm[SAVE][AW-1:0]); m_ie = 1'b1; nt = "R10"; end
      default: nt = "R5";
    endcase
    if (m_irq && m_ie) begin
      push(2, SAVE, m_pc, "R8"); mm[SAVE] = DW'(m_pc);
      m_pc = HND; m_ie = 1'b0; m_irq = 1'b0; nt = "R8";
    end else if (m_irq) nt = "R9";
    m_tag = nt;
  endtask

  // monitor: compare every completed transfer, track held requests
  bit done = 1'b0, f1 = 1'b0, f2 = 1'b0, in_req = 1'b0;
  int end_hits = 0, req_addr = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if ((mem_rd || mem_wr) && !in_req) begin in_req = 1'b1; req_addr = int'(mem_addr); end
      if ((mem_rd || mem_wr) && mem_ready) begin
        int k, a, d, ea, es;
        string rq;
        in_req = 1'b0;
        if (q_kind.size() == 0) model_step();
        k = q_kind.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
        ea = q_acc.pop_front(); es = q_st.pop_front(); rq = q_req.pop_front();
        chk(!(mem_rd && mem_wr), "R11", "both strobes", int'({mem_rd, mem_wr}), 2);
        chk(req_addr == int'(mem_addr), "R11", "address held", int'(mem_addr), req_addr);
        chk(int'(mem_wr) == (k == 2 ? 1 : 0), rq, "direction", int'(mem_wr), k == 2 ? 1 : 0);
        chk(int'(mem_addr) == a, rq, "address", int'(mem_addr), a);
        if (k == 2) chk(int'(mem_wdata) == d, rq, "write data", int'(mem_wdata), d);
        if (k == 0) begin
          chk(int'(acc_o) == ea, rq, "accumulator at fetch", int'(acc_o), ea);
          chk(int'(status_o) == es, rq, "status at fetch", int'(status_o), es);
          if (a == TRIG1 && !f1) begin irq <= 1'b1; f1 = 1'b1; end
          if (a == TRIG2 && !f2) begin irq <= 1'b1; f2 = 1'b1; end
          if (a == ENDPC) begin end_hits++; if (end_hits == 3) done = 1'b1; end
        end
        if (k == 2 && a == SAVE) irq <= 1'b0;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = prog(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!mem_rd && !mem_wr, "R12", "no request in reset", int'({mem_rd, mem_wr}), 0);
    chk(acc_o == '0, "R12", "accumulator reset", int'(acc_o), 0);
    chk(status_o == 5'b10000, "R12", "status reset", int'(status_o), 'h10);
    rst_n = 1'b1;
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    chk(done, "R1", "watchdog expired", 0, 1);
    @(negedge clk);
    chk(mem[8'h86] == 13'h1000, "R4", "ADD overflow result", int'(mem[8'h86]), 'h1000);
    chk(mem[8'h87] == 13'h0000, "R6", "skipped stores untouched", int'(mem[8'h87]), 0);
    chk(mem[8'h85] == 13'h0000, "R7", "ISZ counter wrapped", int'(mem[8'h85]), 0);
    chk(mem[8'h88] == 13'h0F0F, "R3", "AND result stored", int'(mem[8'h88]), 'h0F0F);
    chk(mem[8'h84] == 13'h0F0E, "R2", "indirect store", int'(mem[8'h84]), 'h0F0E);
    chk(mem[8'h89] == 13'h0001, "R9", "second entry only after return", int'(mem[8'h89]), 1);
    chk(mem[SAVE] == 13'd13, "R10", "saved return address", int'(mem[SAVE]), 13);
    for (int i = 128; i < 256; i++)
      chk(mem[i] == mm[i], "R3", "memory image", int'(mem[i]), int'(mm[i]));
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule